// File: doc/BRIEF.md
# Eye Opening Lock Monitor

The block checks, at a programmable interval, that a clock-data-recovery loop still sees an open eye. It takes over an offset comparator that sits beside the data slicer. It drives a phase offset code and a voltage offset code to that comparator. For each code it waits for one dwell result, which is a valid strobe carrying a flag that says whether the offset comparator disagreed with the main slicer during that dwell.

Each measurement has two sweeps of 64 steps. The first sweep steps the phase across one unit interval while the voltage code sits at mid-scale. The longest run of consecutive error-free steps gives the horizontal opening. The middle of that run becomes the phase for the second sweep, which steps the voltage code and measures the vertical opening the same way. Both openings are stored as bytes, and a one-cycle done pulse marks their update. If either opening is smaller than its threshold, a relock request is pulsed with done. Clearing the enable stops new measurements, which frees the comparator for an external full scan. A measurement that is already running always finishes.

Top module: `eye_lock_mon`

## Requirements
- R1: After reset the block is idle. Both offset codes are at mid-scale (32), busy is 0, both results are 0, and done and relock are 0.
- R2: With enable high and the interval counter at zero, the block leaves idle at the next clock edge. busy is 1 for the whole measurement. Clearing enable zeroes the counter, so a later enable starts at once.
- R3: In the horizontal sweep the phase code starts at 0 and rises by one on each dwell strobe, up to 63. The voltage code stays at 32.
- R4: The horizontal result is the length (0 to 64) of the longest run of consecutive error-free phase steps. If two runs are equally long, the earlier one wins.
- R5: In the vertical sweep the phase code holds at start + floor(length/2) of the winning horizontal run, or at 32 if that run is empty. The voltage code steps from 0 to 63 on each strobe.
- R6: The vertical result is the length of the longest error-free run of voltage steps.
- R7: done is high for exactly one cycle, in the cycle when the vertical result is updated. Both results then hold until the next measurement.
- R8: relock is pulsed together with done when the horizontal result is strictly below its threshold or the vertical result is strictly below its threshold.
- R9: When a measurement ends, the interval counter loads the period P. The next measurement starts P+1 cycles after done is seen, if enable stays high.
- R10: Clearing enable during a measurement does not abort it. After that measurement no new one starts, and dwell strobes received while idle change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mon_en_i | input | 1 | Periodic monitoring enable |
| period_i | input | 16 | Idle cycles between measurements |
| heo_thr_i | input | 8 | Minimum acceptable horizontal opening |
| veo_thr_i | input | 8 | Minimum acceptable vertical opening |
| err_valid_i | input | 1 | Dwell result strobe |
| err_hit_i | input | 1 | Dwell saw at least one disagreement |
| phase_code_o | output | 6 | Offset comparator phase code |
| volt_code_o | output | 6 | Offset comparator voltage code |
| busy_o | output | 1 | Measurement in progress |
| heo_o | output | 8 | Latest horizontal opening |
| veo_o | output | 8 | Latest vertical opening |
| done_o | output | 1 | Both results updated this cycle |
| relock_req_o | output | 1 | Opening below threshold, restart acquisition |

## Verification
Two events can fall on the same clock edge. The final vertical dwell strobe can arrive in the same cycle that enable is cleared, and the interval counter's reload then competes with the counter clear. Likewise, the idle counter can expire in the same cycle that a stray dwell strobe arrives. The bench provokes these cases by dropping enable part-way through a measurement and by toggling strobes while the block is idle. A behavioural model tracks the expected state on every clock. The bench judges the result by the done pulse still appearing, by the absence of any later busy cycle, and by the results staying unchanged.

// File: rtl/eye_mon_pkg.sv
package eye_mon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HSWEEP = 2'd1,
    ST_VSWEEP = 2'd2
  } mon_state_e;
endpackage

// File: rtl/eye_run_tracker.sv
module eye_run_tracker #(
  parameter int STEP_W = 6,
  localparam int RUN_W = STEP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic              err_i,
  input  logic [STEP_W-1:0] idx_i,
  output logic [RUN_W-1:0]  nxt_len_o,
  output logic [STEP_W-1:0] nxt_start_o
);
  logic [RUN_W-1:0]  cur_len_q, best_len_q, cur_len_d;
  logic [STEP_W-1:0] cur_start_q, best_start_q, cur_start_d;

  always_comb begin
    if (err_i) begin
      cur_len_d   = '0;
      cur_start_d = cur_start_q;
    end else begin
      cur_len_d   = cur_len_q + 1'b1;
      cur_start_d = (cur_len_q == '0) ? idx_i : cur_start_q;
    end
    // strict compare keeps the earliest of equal runs
    if (cur_len_d > best_len_q) begin
      nxt_len_o   = cur_len_d;
      nxt_start_o = cur_start_d;
    end else begin
      nxt_len_o   = best_len_q;
      nxt_start_o = best_start_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_len_q    <= '0;
      cur_start_q  <= '0;
      best_len_q   <= '0;
      best_start_q <= '0;
    end else if (clear_i) begin
      cur_len_q    <= '0;
      cur_start_q  <= '0;
      best_len_q   <= '0;
      best_start_q <= '0;
    end else if (valid_i) begin
      cur_len_q    <= cur_len_d;
      cur_start_q  <= cur_start_d;
      best_len_q   <= nxt_len_o;
      best_start_q <= nxt_start_o;
    end
  end

  // R4
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> nxt_len_o <= ({1'b0, idx_i} + RUN_W'(1)));
endmodule

// File: rtl/eye_period_timer.sv
module eye_period_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             idle_i,
  input  logic             load_i,
  input  logic [TMR_W-1:0] period_i,
  output logic             expire_o
);
  logic [TMR_W-1:0] cnt_q;

  assign expire_o = en_i && idle_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= period_i;
    else if (!en_i)                  cnt_q <= '0;
    else if (idle_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // R9
  tmr_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(period_i));
endmodule

// File: rtl/eye_sweep_ctrl.sv
module eye_sweep_ctrl
  import eye_mon_pkg::*;
#(
  parameter int STEP_W = 6,
  parameter int RES_W  = 8,
  localparam int RUN_W = STEP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              err_valid_i,
  input  logic [RES_W-1:0]  heo_thr_i,
  input  logic [RES_W-1:0]  veo_thr_i,
  input  logic [RUN_W-1:0]  trk_len_i,
  input  logic [STEP_W-1:0] trk_start_i,
  output logic              trk_clear_o,
  output logic              trk_valid_o,
  output logic [STEP_W-1:0] step_o,
  output logic              idle_o,
  output logic              load_o,
  output logic [STEP_W-1:0] phase_code_o,
  output logic [STEP_W-1:0] volt_code_o,
  output logic [RES_W-1:0]  heo_o,
  output logic [RES_W-1:0]  veo_o,
  output logic              done_o,
  output logic              relock_o
);
  localparam logic [STEP_W-1:0] MID = STEP_W'(1) << (STEP_W - 1);

  mon_state_e        state_q;
  logic [STEP_W-1:0] step_q, centre_q;
  logic [RES_W-1:0]  heo_q, veo_q;
  logic              done_q, relock_q;
  logic              last, in_sweep;
  logic [RUN_W-1:0]  centre_w;
  logic [RES_W-1:0]  len_res;

  assign last        = (step_q == '1);
  assign in_sweep    = (state_q != ST_IDLE);
  assign trk_valid_o = err_valid_i && in_sweep;
  assign trk_clear_o = (state_q == ST_IDLE && start_i) ||
                       (state_q == ST_HSWEEP && err_valid_i && last);
  assign load_o      = (state_q == ST_VSWEEP) && err_valid_i && last;
  assign idle_o      = !in_sweep;
  assign step_o      = step_q;
  assign centre_w    = {1'b0, trk_start_i} + (trk_len_i >> 1);
  assign len_res     = RES_W'(trk_len_i);

  always_comb begin
    phase_code_o = MID;
    volt_code_o  = MID;
    case (state_q)
      ST_HSWEEP: phase_code_o = step_q;
      ST_VSWEEP: begin
        phase_code_o = centre_q;
        volt_code_o  = step_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      centre_q <= MID;
      heo_q    <= '0;
      veo_q    <= '0;
      done_q   <= 1'b0;
      relock_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      relock_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_HSWEEP;
          step_q  <= '0;
        end
        ST_HSWEEP: if (err_valid_i) begin
          if (last) begin
            state_q  <= ST_VSWEEP;
            step_q   <= '0;
            heo_q    <= len_res;
            centre_q <= (trk_len_i == '0) ? MID : centre_w[STEP_W-1:0];
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_VSWEEP: if (err_valid_i) begin
          if (last) begin
            state_q  <= ST_IDLE;
            veo_q    <= len_res;
            done_q   <= 1'b1;
            relock_q <= (heo_q < heo_thr_i) || (len_res < veo_thr_i);
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign heo_o    = heo_q;
  assign veo_o    = veo_q;
  assign done_o   = done_q;
  assign relock_o = relock_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R8
  relock_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_q |-> done_q);
  // R7
  veo_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(veo_q) |-> done_q);
  // R5
  centre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_VSWEEP && $past(state_q) == ST_VSWEEP) |-> $stable(phase_code_o));
  // R3
  step_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sweep && err_valid_i && !last) |=> step_q == $past(step_q) + 1'b1);
endmodule

// File: rtl/eye_lock_mon.sv
module eye_lock_mon #(
  parameter int STEP_W = 6,
  parameter int TMR_W  = 16,
  parameter int RES_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mon_en_i,
  input  logic [TMR_W-1:0]  period_i,
  input  logic [RES_W-1:0]  heo_thr_i,
  input  logic [RES_W-1:0]  veo_thr_i,
  input  logic              err_valid_i,
  input  logic              err_hit_i,
  output logic [STEP_W-1:0] phase_code_o,
  output logic [STEP_W-1:0] volt_code_o,
  output logic              busy_o,
  output logic [RES_W-1:0]  heo_o,
  output logic [RES_W-1:0]  veo_o,
  output logic              done_o,
  output logic              relock_req_o
);
  localparam int RUN_W = STEP_W + 1;

  logic              start, idle, load, trk_clear, trk_valid;
  logic [STEP_W-1:0] step, trk_start;
  logic [RUN_W-1:0]  trk_len;

  eye_period_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (mon_en_i),
    .idle_i   (idle),
    .load_i   (load),
    .period_i (period_i),
    .expire_o (start)
  );

  eye_run_tracker #(.STEP_W(STEP_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (trk_clear),
    .valid_i     (trk_valid),
    .err_i       (err_hit_i),
    .idx_i       (step),
    .nxt_len_o   (trk_len),
    .nxt_start_o (trk_start)
  );

  eye_sweep_ctrl #(.STEP_W(STEP_W), .RES_W(RES_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .err_valid_i  (err_valid_i),
    .heo_thr_i    (heo_thr_i),
    .veo_thr_i    (veo_thr_i),
    .trk_len_i    (trk_len),
    .trk_start_i  (trk_start),
    .trk_clear_o  (trk_clear),
    .trk_valid_o  (trk_valid),
    .step_o       (step),
    .idle_o       (idle),
    .load_o       (load),
    .phase_code_o (phase_code_o),
    .volt_code_o  (volt_code_o),
    .heo_o        (heo_o),
    .veo_o        (veo_o),
    .done_o       (done_o),
    .relock_o     (relock_req_o)
  );

  assign busy_o = !idle;

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !mon_en_i) |=> (idle && $stable(heo_o)));
endmodule

// File: tb/eye_lock_mon_test.sv
module eye_lock_mon_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [15:0] period = 16'd0;
  logic [7:0] hthr = 8'd0, vthr = 8'd0;
  logic       vld = 1'b0, hit = 1'b0;
  logic [5:0] phase, volt;
  logic       busy, done, relock;
  logic [7:0] heo, veo;

  int checks = 0, errors = 0;
  bit finished = 0;

  int hlo = 0, hhi = 63, vlo = 0, vhi = 63, hole = 99;
  bit idle_noise = 0;

  // model state
  int m_mode = 0, m_step = 0, m_timer = 0, m_centre = 32;
  int m_heo = 0, m_veo = 0;
  bit m_done = 0, m_relock = 0;
  int harr[64];
  int varr[64];

  always #4 clk = ~clk;

  eye_lock_mon uut (
    .clk_i(clk), .rst_ni(rst_n), .mon_en_i(en), .period_i(period),
    .heo_thr_i(hthr), .veo_thr_i(vthr), .err_valid_i(vld), .err_hit_i(hit),
    .phase_code_o(phase), .volt_code_o(volt), .busy_o(busy),
    .heo_o(heo), .veo_o(veo), .done_o(done), .relock_req_o(relock)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic longest(input int a[64], output int len, output int st);
    int cur;
    cur = 0; len = 0; st = 0;
    for (int i = 0; i < 64; i++) begin
      if (a[i] == 0) begin
        cur++;
        if (cur > len) begin len = cur; st = i - cur + 1; end
      end else cur = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_step = 0; m_timer = 0; m_centre = 32;
      m_heo = 0; m_veo = 0; m_done = 0; m_relock = 0;
    end else begin
      int l, s;
      m_done = 0; m_relock = 0;
      if (m_mode == 0) begin
        if (!en) m_timer = 0;
        else if (m_timer == 0) begin m_mode = 1; m_step = 0; end
        else m_timer--;
      end else begin
        if (!en) m_timer = 0;
        if (vld) begin
          if (m_mode == 1) harr[m_step] = hit; else varr[m_step] = hit;
          if (m_step < 63) m_step++;
          else if (m_mode == 1) begin
            longest(harr, l, s);
            m_heo = l;
            m_centre = (l == 0) ? 32 : s + l / 2;
            m_mode = 2; m_step = 0;
          end else begin
            longest(varr, l, s);
            m_veo = l;
            m_done = 1;
            m_relock = (m_heo < hthr) || (m_veo < vthr);
            m_mode = 0; m_timer = period;
          end
        end
      end
    end
  end

  // per-cycle comparison and dwell responder
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 busy", busy, m_mode != 0);
      check(m_mode == 2 ? "R5 phase" : "R3 phase", phase,
            m_mode == 1 ? m_step : (m_mode == 2 ? m_centre : 32));
      check(m_mode == 2 ? "R5 volt" : "R3 volt", volt, m_mode == 2 ? m_step : 32);
      check("R4 heo", heo, m_heo);
      check("R6 veo", veo, m_veo);
      check("R7 done", done, m_done);
      check("R8 relock", relock, m_relock);
    end
    if (m_mode != 0) begin
      vld = ~vld;
      if (m_mode == 1) hit = (phase < hlo) || (phase > hhi) || (phase == hole);
      else hit = (phase < hlo) || (phase > hhi) || (volt < vlo) || (volt > vhi);
    end else begin
      vld = idle_noise ? ~vld : 1'b0;
      hit = 1'b0;
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic measure(input int hl, input int hh, input int ho, input int vl,
                         input int vh, input int ht, input int vt);
    en = 0;
    repeat (3) @(negedge clk);
    hlo = hl; hhi = hh; hole = ho; vlo = vl; vhi = vh;
    hthr = 8'(ht); vthr = 8'(vt);
    en = 1;
    wait_done();
    en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 phase", phase, 32);
    check("R1 volt", volt, 32);
    check("R1 heo", heo, 0);
    check("R1 done", done, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 start at once when enabled with zeroed counter
    period = 16'd20; hlo = 16; hhi = 47; hole = 99; vlo = 8; vhi = 55;
    hthr = 8'd32; vthr = 8'd48;
    en = 1;
    @(negedge clk);
    check("R2 start", busy, 1);
    check("R3 first phase", phase, 0);
    wait_done();
    check("R4 heo wide", heo, 32);
    check("R6 veo wide", veo, 48);
    check("R8 equal thresholds", relock, 0);
    // R9 period
    k = 0;
    do begin @(negedge clk); k++; end while (!busy && k < 100);
    check("R9 interval", k, 21);
    wait_done();
    en = 0;
    @(negedge clk);
    check("R7 single pulse", done, 0);

    // R4 R5 tie: runs 10..24 and 26..40, centre 17
    measure(10, 40, 25, 20, 43, 16, 10);
    check("R4 tie heo", heo, 15);
    check("R6 veo", veo, 24);
    check("R8 relock", relock, 1);

    // R5 closed eye: centre falls back to 32
    measure(1, 0, 99, 0, 63, 1, 1);
    check("R4 closed heo", heo, 0);
    check("R6 closed veo", veo, 0);
    check("R8 closed relock", relock, 1);

    // fully open eye
    measure(0, 63, 99, 0, 63, 64, 64);
    check("R4 open heo", heo, 64);
    check("R6 open veo", veo, 64);
    check("R8 open relock", relock, 0);

    // R10 disable mid-measurement
    hlo = 5; hhi = 30; hole = 99; vlo = 12; vhi = 40;
    en = 1;
    repeat (60) @(negedge clk);
    en = 0;
    wait_done();
    check("R10 completes heo", heo, 26);
    check("R10 completes veo", veo, 29);
    idle_noise = 1;
    k = 0;
    repeat (400) begin @(negedge clk); if (busy) k++; end
    check("R10 no restart", k, 0);
    check("R10 heo held", heo, 26);
    check("R7 veo held", veo, 29);
    idle_noise = 0;
    finish_run();
  end
endmodule